// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block is a target on a two-wire serial bus (I2C-compatible). Through it a bus host reads and writes a small internal register file. The block samples the bus clock and data lines with a much faster system clock. It drives the data line only by pulling it low through an enable output, and never drives it high.

A transfer starts with an address byte. Its upper six bits are fixed and one bit comes from a strap input. The byte after a write address loads an internal subaddress pointer, and every later byte is stored at that pointer, which then advances. To read, the host first sets the pointer with a write phase. It then issues a repeated START with the read address and clocks bytes out until it declines one. Out-of-range accesses are handled differently for each direction. A read that runs past the top of the map keeps returning the top register. A write that runs past the top is refused.

Top module: `sbr_i2c_target`

## Requirements
- R1: The target answers the 7-bit address {6'b010000, addr_sel}, sent as the top seven bits of the address byte, with bit 0 of that byte selecting read (1) or write (0). This gives write bytes 0x40 or 0x42 and read bytes 0x41 or 0x43. Any other address gets no acknowledge, and the bytes that follow it have no effect until the next START.
- R2: A START (data falling while clock is high) restarts address reception from any state, including a repeated START in the middle of a transfer. A STOP (data rising while clock is high) returns the target to idle from any state, and a byte cut short by it is discarded.
- R3: On an address match the target pulls data low for the ninth clock pulse and releases it after that pulse's falling edge.
- R4: In a write, the byte after the address sets the pointer. Each later byte is stored at the pointer and acknowledged, and the pointer then advances by one. Registers not addressed keep their contents.
- R5: A subaddress byte that is in 0x30..0x37 or above 0x3F is not acknowledged. The target goes idle, the pointer keeps its previous value, and the following bytes are ignored.
- R6: After a read address, bytes are sent MSB first from the pointer, and the pointer advances after each byte. Sending continues while the host acknowledges. After a host NACK the target releases the data line and goes idle.
- R7: Once a read passes subaddress 0x3F, every further byte returns the contents of register 0x3F.
- R8: A write byte aimed past 0x3F is not stored and not acknowledged, and the target goes idle.
- R9: Subaddresses 0x30..0x37 hold no storage. They read as 0x00, and a write that reaches them by auto-increment is refused in the same way as R8.
- R10: After reset every register reads 0x00, the pointer is 0x00, and the data line is released.
- R11: The pull-down enable changes only while the sampled bus clock is low. The bus clock must be at least four times slower than the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_sel | input | 1 | Strap that sets bit 1 of the address byte |
| sda_pull_o | output | 1 | High pulls the data line low; low releases it |

## Verification
Every write address byte from 0x00 to 0xFE is offered with the strap low. This separates the single matching address from its neighbours, and the strap is then flipped to show that only bit 1 moves. Long write and read bursts that run through the whole map tell the stored registers apart from the reserved hole and from the clamp at the top. Refused subaddresses, a foreign address and a STOP in the middle of a byte are each followed by bytes or by a read-back. These show that nothing reached storage or the pointer, while the repeated STARTs inside every read show that address reception restarts.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    parameter int DATA_W    = 8;
    parameter int SUB_W     = 6;
    parameter int MAP_DEPTH = 1 << SUB_W;
    parameter int PTR_W     = SUB_W + 1;
    parameter int TOP_SUB   = MAP_DEPTH - 1;
    parameter int HOLE_LO   = 'h30;
    parameter int HOLE_HI   = 'h37;
    parameter logic [5:0] DEV_ID_HI = 6'b010000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } xfer_state_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_SUB,
        RX_DATA
    } rx_role_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    // true when a subaddress maps to real storage
    function automatic logic sub_ok(input int s);
        return (s >= 0) && (s < MAP_DEPTH) && !((s >= HOLE_LO) && (s <= HOLE_HI));
    endfunction
endpackage

// File: rtl/sbr_line_sync.sv
module sbr_line_sync
    import sbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_pin,
    input  logic     sda_pin,
    output line_ev_t ev
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_q;
    logic       sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_pin};
            sda_ff <= {sda_ff[0], sda_pin};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[1];
        ev.sda      = sda_ff[1];
        ev.scl_rise = scl_ff[1] & ~scl_q;
        ev.scl_fall = ~scl_ff[1] & scl_q;
        ev.start    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
        ev.stop     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
    end
endmodule

// File: rtl/sbr_regfile.sv
module sbr_regfile
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SUB_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SUB_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [MAP_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAP_DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = sub_ok(int'(raddr)) ? mem[raddr] : '0;

    // R9: the controller never commits a write into the hole
    assert_wr_in_map_R9: assert property (@(posedge clk) disable iff (rst)
        we |-> sub_ok(int'(waddr)));
endmodule

// File: rtl/sbr_xfer_ctrl.sv
module sbr_xfer_ctrl
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              strap,
    output logic              rf_we,
    output logic [SUB_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [SUB_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              sda_pull
);
    xfer_state_e       st;
    rx_role_e          role;
    logic [3:0]        cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] txsr;
    logic [PTR_W-1:0]  ptr;
    logic              is_read;
    logic              mack;
    logic              pull;

    logic [6:0]        my_addr;
    logic              byte_done;
    logic              wr_ok;
    logic [PTR_W-1:0]  ptr_adv;

    assign my_addr   = {DEV_ID_HI, strap};
    assign byte_done = ev.scl_fall && (cnt == 4'd8);
    assign wr_ok     = !ptr[PTR_W-1] && sub_ok(int'(ptr[SUB_W-1:0]));
    assign ptr_adv   = ptr[PTR_W-1] ? ptr : ptr + 1'b1;

    assign rf_raddr  = ptr[PTR_W-1] ? SUB_W'(TOP_SUB) : ptr[SUB_W-1:0];
    assign rf_waddr  = ptr[SUB_W-1:0];
    assign rf_wdata  = shreg;
    assign rf_we     = (st == ST_RX) && (role == RX_DATA) && byte_done && wr_ok;
    assign sda_pull  = pull;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            role    <= RX_ADDR;
            cnt     <= '0;
            shreg   <= '0;
            txsr    <= '0;
            ptr     <= '0;
            is_read <= 1'b0;
            mack    <= 1'b0;
            pull    <= 1'b0;
        end else if (ev.start) begin
            st   <= ST_RX;
            role <= RX_ADDR;
            cnt  <= '0;
            pull <= 1'b0;
        end else if (ev.stop) begin
            st   <= ST_IDLE;
            pull <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (ev.scl_rise && cnt < 4'd8) begin
                        shreg <= {shreg[DATA_W-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        unique case (role)
                            RX_ADDR: begin
                                if (shreg[7:1] == my_addr) begin
                                    is_read <= shreg[0];
                                    st      <= ST_ACK;
                                    pull    <= 1'b1;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            RX_SUB: begin
                                if (sub_ok(int'(shreg))) begin
                                    ptr  <= shreg[PTR_W-1:0];
                                    st   <= ST_ACK;
                                    pull <= 1'b1;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            default: begin
                                if (wr_ok) begin
                                    ptr  <= ptr + 1'b1;
                                    st   <= ST_ACK;
                                    pull <= 1'b1;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (role == RX_ADDR && is_read) begin
                            st   <= ST_TX;
                            txsr <= rf_rdata;
                            pull <= ~rf_rdata[DATA_W-1];
                            ptr  <= ptr_adv;
                        end else begin
                            pull <= 1'b0;
                            st   <= ST_RX;
                            role <= (role == RX_ADDR) ? RX_SUB : RX_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (cnt == 4'd8) begin
                            pull <= 1'b0;
                            st   <= ST_MACK;
                        end else begin
                            txsr <= {txsr[DATA_W-2:0], 1'b0};
                            pull <= ~txsr[DATA_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack) begin
                            st   <= ST_TX;
                            cnt  <= '0;
                            txsr <= rf_rdata;
                            pull <= ~rf_rdata[DATA_W-1];
                            ptr  <= ptr_adv;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R11: the data line only moves while the bus clock is low
    assert_pull_moves_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(pull) |-> !ev.scl);

    // R2: a STOP always leaves the target idle with the line released
    assert_stop_to_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st == ST_IDLE) && !pull);

    // R7: the read pointer clamps one past the top and never wraps
    assert_ptr_clamped_R7: assert property (@(posedge clk) disable iff (rst)
        ptr[PTR_W-1] |-> (ptr[SUB_W-1:0] == '0));

    // R8: a data byte past the top is refused and the target drops out
    assert_overrun_refused_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX && role == RX_DATA && byte_done && !ev.start && !ev.stop && ptr[PTR_W-1])
        |=> (st == ST_IDLE) && !pull && !rf_we);

    // R5: a bad subaddress leaves the pointer alone and releases the line
    assert_bad_sub_refused_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX && role == RX_SUB && byte_done && !ev.start && !ev.stop && !sub_ok(int'(shreg)))
        |=> (st == ST_IDLE) && !pull && $stable(ptr));
endmodule

// File: rtl/sbr_i2c_target.sv
module sbr_i2c_target
    import sbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel,
    output logic sda_pull_o
);
    line_ev_t          ev;
    logic              rf_we;
    logic [SUB_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [SUB_W-1:0]  rf_raddr;
    logic [DATA_W-1:0] rf_rdata;

    sbr_line_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_pin (scl_i),
        .sda_pin (sda_i),
        .ev      (ev)
    );

    sbr_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    sbr_xfer_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .strap    (addr_sel),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .rf_raddr (rf_raddr),
        .rf_rdata (rf_rdata),
        .sda_pull (sda_pull_o)
    );
endmodule

// File: tb/sim_sbr_i2c_target.sv
module sim_sbr_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_pull_o;
    wire  sda_bus = sda_m & ~sda_pull_o;

    int vecs = 0;
    int errs = 0;
    int viol = 0;
    logic prev_pull = 1'b0;
    logic [7:0] model [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    sbr_i2c_target u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_sel   (strap),
        .sda_pull_o (sda_pull_o)
    );

    // R11 monitor: pull must never change while the bus clock is high
    always @(negedge clk) begin
        if (!rst && (sda_pull_o != prev_pull) && scl_m) viol++;
        prev_pull <= sda_pull_o;
    end

    function automatic logic in_map(input int a);
        return (a < 64) && !(a >= 48 && a <= 55);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        acked = !sda_bus; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl_m = 1'b1; wait_q();
            b[i] = sda_bus; wait_q();
            scl_m = 1'b0;
        end
        wait_q();
        sda_m = !give_ack; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
        sda_m = 1'b1;
    endtask

    // set pointer, repeated START, read n bytes and compare with expectations
    task automatic read_run(input int sub, input int n, input string req);
        logic a;
        logic [7:0] d;
        int exp;
        bus_start();
        put_byte(8'h40, a);
        put_byte(8'(sub), a);
        bus_start();
        put_byte(8'h41, a);
        check(req, a, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, d);
            if (sub + k > 63) exp = model[63];
            else exp = in_map(sub + k) ? model[sub + k] : 0;
            check(req, d, exp);
        end
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R10: released line, registers and pointer cleared
        check("R10", sda_pull_o, 0);
        bus_start();
        put_byte(8'h41, a);
        check("R10", a, 1);
        get_byte(1'b1, d); check("R10", d, 0);
        get_byte(1'b0, d); check("R10", d, 0);
        bus_stop();

        // R1/R3: sweep every write address byte, only 0x40 answers
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            put_byte({7'(ad), 1'b0}, a);
            check("R1", a, (ad == 'h20) ? 1 : 0);
            if (ad == 'h20) check("R3", sda_pull_o, 0);
            bus_stop();
        end

        // R4: burst write across the lower map
        bus_start();
        put_byte(8'h40, a);
        put_byte(8'h00, a); check("R4", a, 1);
        for (int k = 0; k < 48; k++) begin
            model[k] = 8'((k * 37 + 5) & 255);
            put_byte(model[k], a);
            check("R4", a, 1);
        end
        bus_stop();

        // R8: write to top of map, then one byte too far
        bus_start();
        put_byte(8'h40, a);
        put_byte(8'h38, a); check("R4", a, 1);
        for (int k = 56; k < 64; k++) begin
            model[k] = 8'((k * 11 + 3) & 255);
            put_byte(model[k], a);
            check("R4", a, 1);
        end
        put_byte(8'hEE, a); check("R8", a, 0);
        bus_stop();

        // R6/R7/R9: one read through the whole map and past the top
        read_run(0, 67, "R7");
        check("R6", sda_pull_o, 0);

        // R9: auto-increment into the hole is refused
        bus_start();
        put_byte(8'h40, a);
        put_byte(8'h2E, a); check("R9", a, 1);
        put_byte(8'hA1, a); check("R9", a, 1); model[46] = 8'hA1;
        put_byte(8'hB2, a); check("R9", a, 1); model[47] = 8'hB2;
        put_byte(8'hC3, a); check("R9", a, 0);
        bus_stop();
        read_run(46, 4, "R9");

        // R5: bad subaddresses leave pointer and storage untouched
        bus_start();
        put_byte(8'h40, a);
        put_byte(8'h10, a); check("R5", a, 1);
        bus_stop();
        for (int s = 0; s < 4; s++) begin
            bus_start();
            put_byte(8'h40, a);
            put_byte((s == 0) ? 8'h30 : (s == 1) ? 8'h37 : (s == 2) ? 8'h40 : 8'hFF, a);
            check("R5", a, 0);
            put_byte(8'h5A, a); check("R5", a, 0);
            bus_stop();
        end
        bus_start();
        put_byte(8'h41, a);
        get_byte(1'b0, d); check("R5", d, model[16]);
        bus_stop();

        // R1: traffic to a foreign address is ignored
        bus_start();
        put_byte(8'h44, a); check("R1", a, 0);
        put_byte(8'h05, a); check("R1", a, 0);
        put_byte(8'h77, a); check("R1", a, 0);
        bus_stop();
        read_run(5, 1, "R1");

        // R2: STOP in the middle of a byte discards it
        bus_start();
        put_byte(8'h40, a);
        put_byte(8'h05, a);
        put_byte(8'h99, a); check("R2", a, 1); model[5] = 8'h99;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        check("R2", sda_pull_o, 0);
        read_run(5, 2, "R2");

        // R1: strap moves address bit 1
        strap = 1'b1;
        repeat (4) @(negedge clk);
        bus_start();
        put_byte(8'h40, a); check("R1", a, 0);
        bus_stop();
        bus_start();
        put_byte(8'h42, a); check("R1", a, 1);
        put_byte(8'h20, a);
        put_byte(8'h3C, a); check("R4", a, 1); model[32] = 8'h3C;
        bus_stop();
        bus_start();
        put_byte(8'h42, a);
        put_byte(8'h1F, a);
        bus_start();
        put_byte(8'h43, a); check("R1", a, 1);
        get_byte(1'b1, d); check("R4", d, model[31]);
        get_byte(1'b1, d); check("R4", d, 8'h3C);
        get_byte(1'b0, d); check("R4", d, model[33]);
        bus_stop();
        strap = 1'b0;

        check("R11", viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule